// File: doc/BRIEF.md
# Up/Down Position Counter with Dual Compare

This block is the counting core of a position or event counter. A separate input decoder turns encoder phases or pulse trains into single-cycle count-up and count-down strobes, and this block keeps a wide binary count from them. The count can be set in three ways. A host can write it directly. A pre-staged value can be transferred in one step by a load strobe. A clear input zeroes it, either through the clocked path or at once, without waiting for a clock edge. A snapshot strobe freezes the running count into a readable register. This allows the host to read a consistent value while counting goes on.

Two reference registers are compared with the count. Comparator A always operates. Comparator B operates only in the extended system mode. That mode is chosen by a mode command and tracked by a two-state machine: `SYS_MODE0` after reset, and `SYS_MODE1`. The machine moves from `SYS_MODE0` to `SYS_MODE1` on a mode command with value 1, and back on a mode command with value 0. Each channel also has a sticky event flag, built as a two-state machine. It moves from `FLAG_IDLE` to `FLAG_HELD` on a new equality event. It moves from `FLAG_HELD` back to `FLAG_IDLE` on a status-read acknowledge that has no new event in the same cycle. Two external flag pins carry comparator results, sticky flags or an input-fault indication, selected per pin in the extended mode.

The counter applies one action per rising edge, chosen by a fixed priority: `ACT_CLEAR`, then `ACT_LOAD`, then `ACT_WRITE`, then `ACT_UP` or `ACT_DOWN`, otherwise `ACT_HOLD`.

Top module: `updown_cmp_counter`

## Requirements
- R1: While `rst_n` is low, and directly after it rises, `count_q` and `snap_q` are 0, the system mode is `SYS_MODE0` (`ext_b_oe` = 0), both sticky flags are in `FLAG_IDLE` and `ext_b` is 0.
- R2: On a rising edge, `cnt_up`=1 with `cnt_dn`=0 adds one to the count, and `cnt_dn`=1 with `cnt_up`=0 subtracts one. Both high, or both low, leave the count unchanged.
- R3: The count wraps modulo 2^W: one step up from all-ones gives 0, and one step down from 0 gives all-ones.
- R4: `load_stb` is sampled on the falling clock edge. When it is seen high there, the following rising edge copies the preload register into the count. This takes priority over a direct write and over count strobes.
- R5: `snap_stb` is sampled on the falling clock edge. When it is seen high there, `snap_q` takes the count value at that falling edge. Otherwise `snap_q` keeps its value.
- R6: With `clr_async_mode`=0, `clr_in` sampled high on a rising edge sets the count to 0 at that edge. This takes priority over load, write and count strobes.
- R7: With `clr_async_mode`=1, `clr_in` high forces the count to 0 at once, without a clock edge, and holds it at 0 while it stays high.
- R8: `wr_count` writes `wr_data` into the count at the next rising edge. It ranks below clear and load, and above count strobes. `wr_preload`, `wr_refa` and `wr_refb` write `wr_data` into their registers at the next rising edge.
- R9: `eq_a` is 1 exactly when the count equals reference A. `eq_b` is 1 exactly when the mode is `SYS_MODE1` and the count equals reference B; in `SYS_MODE0` it is 0.
- R10: A rising edge with `mode_wr`=1 sets the mode to `SYS_MODE1` if `mode_val`=1, or to `SYS_MODE0` if `mode_val`=0. `ext_b_oe` is 1 exactly in `SYS_MODE1`.
- R11: In `SYS_MODE0`, `ext_a` = `eq_a`. In `SYS_MODE1`, `exta_sel` chooses the source: 0 gives `eq_a`, 1 gives `eq_a | eq_b`, 2 gives sticky flag A, 3 gives `eq_a`.
- R12: In `SYS_MODE0`, `ext_b` is 0. In `SYS_MODE1`, `extb_sel` chooses the source: 0 gives `eq_b`, 1 gives `abn_in`, 2 gives sticky flag B, 3 gives `eq_b`.
- R13: A sticky flag is set by the rising edge at which its comparator output is 1 after being 0 at the previous rising edge. It is cleared by a rising edge with `status_rd`=1, unless a new event occurs at that same edge, in which case it stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; counting on the rising edge, load and snapshot strobes on the falling edge |
| rst_n | input | 1 | Asynchronous system reset, active low |
| cnt_up | input | 1 | Count-up strobe from the input decoder |
| cnt_dn | input | 1 | Count-down strobe from the input decoder |
| clr_in | input | 1 | Counter clear, active high |
| clr_async_mode | input | 1 | 1: clear acts asynchronously; 0: clear acts at the rising edge |
| load_stb | input | 1 | Transfer preload register into count |
| snap_stb | input | 1 | Capture count into the snapshot register |
| wr_data | input | W | Write data for count, preload and references |
| wr_preload | input | 1 | Write enable, preload register |
| wr_refa | input | 1 | Write enable, reference A |
| wr_refb | input | 1 | Write enable, reference B |
| wr_count | input | 1 | Write enable, count |
| mode_wr | input | 1 | System mode command strobe |
| mode_val | input | 1 | Mode carried by the command (0 or 1) |
| exta_sel | input | 2 | Source select for `ext_a` in mode 1 |
| extb_sel | input | 2 | Source select for `ext_b` in mode 1 |
| abn_in | input | 1 | Input-fault indication from the decoder |
| status_rd | input | 1 | Status-read acknowledge, clears sticky flags |
| count_q | output | W | Current count |
| snap_q | output | W | Snapshot register |
| eq_a | output | 1 | Count equals reference A |
| eq_b | output | 1 | Count equals reference B (mode 1 only) |
| ext_a | output | 1 | External flag A |
| ext_b | output | 1 | External flag B |
| ext_b_oe | output | 1 | High when `ext_b` is driven (mode 1) |

## Verification
The results of register writes, count strobes, synchronous clear, mode commands and the load transfer become visible after the first rising edge that follows the stimulus. A snapshot settles at the falling edge inside that same cycle. An asynchronous clear shows with no edge at all. The comparator outputs follow the count in the same cycle. A sticky flag is due one rising edge after its comparator output rises, which is two edges after the count strobe that caused it. The bench drives inputs 1 ns after a rising edge, updates its cycle model with the same edge ordering, and compares every output 1 ns after the next rising edge. The one exception is the asynchronous clear, which is compared 2 ns after it is asserted, before any edge.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    localparam int NCH = 2;

    typedef enum logic {
        SYS_MODE0 = 1'b0,
        SYS_MODE1 = 1'b1
    } sys_mode_e;

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_HELD = 1'b1
    } flag_state_e;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_CLEAR,
        ACT_LOAD,
        ACT_WRITE,
        ACT_UP,
        ACT_DOWN
    } ctr_act_e;

    typedef enum logic [1:0] {
        XA_EQ     = 2'd0,
        XA_EQ_OR  = 2'd1,
        XA_STICKY = 2'd2,
        XA_EQ_ALT = 2'd3
    } exta_src_e;

    typedef enum logic [1:0] {
        XB_EQ     = 2'd0,
        XB_ABN    = 2'd1,
        XB_STICKY = 2'd2,
        XB_EQ_ALT = 2'd3
    } extb_src_e;

endpackage

// File: rtl/ctr_core.sv
module ctr_core
    import ctr_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic         clr_sync,
    input  logic         load_go,
    input  logic [W-1:0] pre_val,
    input  logic         wr_go,
    input  logic [W-1:0] wr_val,
    input  logic         up,
    input  logic         dn,
    output logic [W-1:0] count
);

    ctr_act_e act;

    // Action priority: clear, load, write, then count strobes
    always_comb begin
        if (clr_sync)        act = ACT_CLEAR;
        else if (load_go)    act = ACT_LOAD;
        else if (wr_go)      act = ACT_WRITE;
        else if (up && !dn)  act = ACT_UP;
        else if (dn && !up)  act = ACT_DOWN;
        else                 act = ACT_HOLD;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            count <= '0;
        end else begin
            unique case (act)
                ACT_CLEAR: count <= '0;
                ACT_LOAD:  count <= pre_val;
                ACT_WRITE: count <= wr_val;
                ACT_UP:    count <= count + W'(1);
                ACT_DOWN:  count <= count - W'(1);
                ACT_HOLD:  count <= count;
                default:   count <= count;
            endcase
        end
    end

endmodule

// File: rtl/ctr_capture.sv
module ctr_capture #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_stb,
    input  logic         snap_stb,
    input  logic [W-1:0] count,
    output logic         load_pend,
    output logic [W-1:0] snap_q
);

    // Falling-edge sampling of the transfer strobes; the count is stable here
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_pend <= 1'b0;
            snap_q    <= '0;
        end else begin
            load_pend <= load_stb;
            if (snap_stb) begin
                snap_q <= count;
            end
        end
    end

endmodule

// File: rtl/ctr_match.sv
module ctr_match
    import ctr_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] count,
    input  logic [W-1:0] ref_val,
    input  logic         ack,
    output logic         eq,
    output logic         flag
);

    flag_state_e st_q, st_d;
    logic        eq_prev;
    logic        hit_new;

    assign eq      = en && (count == ref_val);
    assign hit_new = eq && !eq_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eq_prev <= 1'b0;
            st_q    <= FLAG_IDLE;
        end else begin
            eq_prev <= eq;
            st_q    <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLAG_IDLE: if (hit_new)         st_d = FLAG_HELD;
            FLAG_HELD: if (ack && !hit_new) st_d = FLAG_IDLE;
            default:                        st_d = FLAG_IDLE;
        endcase
    end

    assign flag = (st_q == FLAG_HELD);

endmodule

// File: rtl/updown_cmp_counter.sv
module updown_cmp_counter
    import ctr_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_up,
    input  logic         cnt_dn,
    input  logic         clr_in,
    input  logic         clr_async_mode,
    input  logic         load_stb,
    input  logic         snap_stb,
    input  logic [W-1:0] wr_data,
    input  logic         wr_preload,
    input  logic         wr_refa,
    input  logic         wr_refb,
    input  logic         wr_count,
    input  logic         mode_wr,
    input  logic         mode_val,
    input  logic [1:0]   exta_sel,
    input  logic [1:0]   extb_sel,
    input  logic         abn_in,
    input  logic         status_rd,
    output logic [W-1:0] count_q,
    output logic [W-1:0] snap_q,
    output logic         eq_a,
    output logic         eq_b,
    output logic         ext_a,
    output logic         ext_b,
    output logic         ext_b_oe
);

    logic            arst_n;
    logic            clr_sync;
    logic            load_pend;
    logic [W-1:0]    preload_q;
    logic [W-1:0]    ref_q [NCH];
    logic [NCH-1:0]  ref_we;
    logic [NCH-1:0]  ch_en;
    logic [NCH-1:0]  eq_vec;
    logic [NCH-1:0]  flag_vec;
    sys_mode_e       mode_q, mode_d;
    exta_src_e       xa_src;
    extb_src_e       xb_src;

    assign arst_n   = rst_n & ~(clr_in & clr_async_mode);
    assign clr_sync = clr_in & ~clr_async_mode;
    assign ref_we   = {wr_refb, wr_refa};

    // System mode state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= SYS_MODE0;
        else        mode_q <= mode_d;
    end

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            SYS_MODE0: if (mode_wr && mode_val)  mode_d = SYS_MODE1;
            SYS_MODE1: if (mode_wr && !mode_val) mode_d = SYS_MODE0;
            default:                             mode_d = SYS_MODE0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          preload_q <= '0;
        else if (wr_preload) preload_q <= wr_data;
    end

    ctr_core #(.W(W)) u_core (
        .clk      (clk),
        .arst_n   (arst_n),
        .clr_sync (clr_sync),
        .load_go  (load_pend),
        .pre_val  (preload_q),
        .wr_go    (wr_count),
        .wr_val   (wr_data),
        .up       (cnt_up),
        .dn       (cnt_dn),
        .count    (count_q)
    );

    ctr_capture #(.W(W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_stb  (load_stb),
        .snap_stb  (snap_stb),
        .count     (count_q),
        .load_pend (load_pend),
        .snap_q    (snap_q)
    );

    // Channel 0 always compares; channel 1 only in the extended mode
    always_comb begin
        ch_en    = '0;
        ch_en[0] = 1'b1;
        ch_en[1] = (mode_q == SYS_MODE1);
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         ref_q[g] <= '0;
            else if (ref_we[g]) ref_q[g] <= wr_data;
        end

        ctr_match #(.W(W)) u_match (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (ch_en[g]),
            .count   (count_q),
            .ref_val (ref_q[g]),
            .ack     (status_rd),
            .eq      (eq_vec[g]),
            .flag    (flag_vec[g])
        );
    end

    assign eq_a = eq_vec[0];
    assign eq_b = eq_vec[1];

    // Output process: pin sources depend on the mode state
    always_comb begin
        xa_src   = exta_src_e'(exta_sel);
        xb_src   = extb_src_e'(extb_sel);
        ext_a    = eq_vec[0];
        ext_b    = 1'b0;
        ext_b_oe = 1'b0;
        unique case (mode_q)
            SYS_MODE0: begin
                ext_a = eq_vec[0];
            end
            SYS_MODE1: begin
                ext_b_oe = 1'b1;
                unique case (xa_src)
                    XA_EQ_OR:  ext_a = eq_vec[0] | eq_vec[1];
                    XA_STICKY: ext_a = flag_vec[0];
                    XA_EQ, XA_EQ_ALT: ext_a = eq_vec[0];
                    default:   ext_a = eq_vec[0];
                endcase
                unique case (xb_src)
                    XB_ABN:    ext_b = abn_in;
                    XB_STICKY: ext_b = flag_vec[1];
                    XB_EQ, XB_EQ_ALT: ext_b = eq_vec[1];
                    default:   ext_b = eq_vec[1];
                endcase
            end
            default: ext_a = eq_vec[0];
        endcase
    end

endmodule

// File: rtl/ctr_checker.sv
module ctr_checker #(
    parameter int W = 24
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cnt_up,
    input logic         cnt_dn,
    input logic         clr_in,
    input logic         clr_async_mode,
    input logic         wr_count,
    input logic         load_pend,
    input logic [W-1:0] preload_q,
    input logic [W-1:0] count_q,
    input logic         eq_a,
    input logic         eq_b,
    input logic         ext_a,
    input logic         ext_b,
    input logic         ext_b_oe,
    input logic         flag_a
);

    p_up_step_r2: assert property (@(posedge clk)
        disable iff (!rst_n || (clr_in && clr_async_mode))
        (cnt_up && !cnt_dn && !clr_in && !load_pend && !wr_count)
        |=> (count_q == W'($past(count_q) + W'(1))));

    p_load_pri_r4: assert property (@(posedge clk)
        disable iff (!rst_n || (clr_in && clr_async_mode))
        (load_pend && !clr_in) |=> (count_q == $past(preload_q)));

    p_sync_clear_r6: assert property (@(posedge clk)
        disable iff (!rst_n)
        (clr_in && !clr_async_mode) |=> (count_q == '0));

    p_async_clear_r7: assert property (@(posedge clk)
        disable iff (!rst_n)
        (clr_in && clr_async_mode) |-> (count_q == '0));

    p_eqb_gate_r9: assert property (@(posedge clk)
        disable iff (!rst_n)
        !ext_b_oe |-> !eq_b);

    p_exta_mode0_r11: assert property (@(posedge clk)
        disable iff (!rst_n)
        !ext_b_oe |-> (ext_a == eq_a));

    p_extb_mode0_r12: assert property (@(posedge clk)
        disable iff (!rst_n)
        !ext_b_oe |-> !ext_b);

    p_flag_rise_r13: assert property (@(posedge clk)
        disable iff (!rst_n)
        (eq_a && !$past(eq_a)) |=> flag_a);

endmodule

bind updown_cmp_counter ctr_checker #(.W(W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cnt_up         (cnt_up),
    .cnt_dn         (cnt_dn),
    .clr_in         (clr_in),
    .clr_async_mode (clr_async_mode),
    .wr_count       (wr_count),
    .load_pend      (load_pend),
    .preload_q      (preload_q),
    .count_q        (count_q),
    .eq_a           (eq_a),
    .eq_b           (eq_b),
    .ext_a          (ext_a),
    .ext_b          (ext_b),
    .ext_b_oe       (ext_b_oe),
    .flag_a         (flag_vec[0])
);

// File: tb/sim_updown_cmp_counter.sv
`timescale 1ns/1ps
module sim_updown_cmp_counter;

    localparam int W = 24;
    localparam logic [W-1:0] ALL1 = {W{1'b1}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnt_up = 0, cnt_dn = 0, clr_in = 0, clr_async_mode = 0;
    logic load_stb = 0, snap_stb = 0;
    logic [W-1:0] wr_data = '0;
    logic wr_preload = 0, wr_refa = 0, wr_refb = 0, wr_count = 0;
    logic mode_wr = 0, mode_val = 0;
    logic [1:0] exta_sel = 0, extb_sel = 0;
    logic abn_in = 0, status_rd = 0;
    logic [W-1:0] count_q, snap_q;
    logic eq_a, eq_b, ext_a, ext_b, ext_b_oe;

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic [W-1:0] m_cnt = '0, m_snap = '0, m_pre = '0, m_ra = '0, m_rb = '0;
    logic m_mode = 0, m_fa = 0, m_fb = 0, m_pa = 0, m_pb = 0;

    always #5 clk = ~clk;

    updown_cmp_counter #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .cnt_up(cnt_up), .cnt_dn(cnt_dn),
        .clr_in(clr_in), .clr_async_mode(clr_async_mode),
        .load_stb(load_stb), .snap_stb(snap_stb), .wr_data(wr_data),
        .wr_preload(wr_preload), .wr_refa(wr_refa), .wr_refb(wr_refb),
        .wr_count(wr_count), .mode_wr(mode_wr), .mode_val(mode_val),
        .exta_sel(exta_sel), .extb_sel(extb_sel), .abn_in(abn_in),
        .status_rd(status_rd), .count_q(count_q), .snap_q(snap_q),
        .eq_a(eq_a), .eq_b(eq_b), .ext_a(ext_a), .ext_b(ext_b),
        .ext_b_oe(ext_b_oe)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic f_eqa(logic [W-1:0] c);
        return c == m_ra;
    endfunction

    function automatic logic f_eqb(logic [W-1:0] c);
        return m_mode && (c == m_rb);
    endfunction

    function automatic logic f_exta();
        logic a = f_eqa(m_cnt);
        if (!m_mode) return a;
        case (exta_sel)
            2'd1:    return a | f_eqb(m_cnt);
            2'd2:    return m_fa;
            default: return a;
        endcase
    endfunction

    function automatic logic f_extb();
        if (!m_mode) return 1'b0;
        case (extb_sel)
            2'd1:    return abn_in;
            2'd2:    return m_fb;
            default: return f_eqb(m_cnt);
        endcase
    endfunction

    task automatic compare_all();
        chk("count R2 R3 R4 R6 R8", 32'(count_q), 32'(m_cnt));
        chk("snap R5", 32'(snap_q), 32'(m_snap));
        chk("eq_a R9", 32'(eq_a), 32'(f_eqa(m_cnt)));
        chk("eq_b R9", 32'(eq_b), 32'(f_eqb(m_cnt)));
        chk("mode R10", 32'(ext_b_oe), 32'(m_mode));
        chk("ext_a R11 R13", 32'(ext_a), 32'(f_exta()));
        chk("ext_b R12 R13", 32'(ext_b), 32'(f_extb()));
    endtask

    // One clock: update model from the inputs now applied, then compare
    task automatic tick();
        logic ea, eb, na, nb;
        if (clr_in && clr_async_mode) m_cnt = '0;
        ea = f_eqa(m_cnt);
        eb = f_eqb(m_cnt);
        if (snap_stb) m_snap = m_cnt;
        if (clr_in)                 m_cnt = '0;
        else if (load_stb)          m_cnt = m_pre;
        else if (wr_count)          m_cnt = wr_data;
        else if (cnt_up && !cnt_dn) m_cnt = m_cnt + W'(1);
        else if (cnt_dn && !cnt_up) m_cnt = m_cnt - W'(1);
        na = ea && !m_pa;
        nb = eb && !m_pb;
        m_fa = na ? 1'b1 : (status_rd ? 1'b0 : m_fa);
        m_fb = nb ? 1'b1 : (status_rd ? 1'b0 : m_fb);
        m_pa = ea;
        m_pb = eb;
        if (wr_preload) m_pre = wr_data;
        if (wr_refa)    m_ra = wr_data;
        if (wr_refb)    m_rb = wr_data;
        if (mode_wr)    m_mode = mode_val;
        @(posedge clk);
        #1;
        compare_all();
    endtask

    task automatic idle();
        cnt_up = 0; cnt_dn = 0; clr_in = 0; load_stb = 0; snap_stb = 0;
        wr_preload = 0; wr_refa = 0; wr_refb = 0; wr_count = 0;
        mode_wr = 0; status_rd = 0;
    endtask

    task automatic write_reg(int which, logic [W-1:0] v);
        idle();
        wr_data = v;
        case (which)
            0: wr_preload = 1;
            1: wr_refa = 1;
            2: wr_refb = 1;
            default: wr_count = 1;
        endcase
        tick();
        idle();
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired R1 actual=%0h expected=%0h", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 count in reset", 32'(count_q), 0);
        chk("R1 snap in reset", 32'(snap_q), 0);
        chk("R1 ext_b_oe in reset", 32'(ext_b_oe), 0);
        chk("R1 ext_b in reset", 32'(ext_b), 0);
        rst_n = 1;
        tick();
        chk("R1 count after reset", 32'(count_q), 0);

        // R3: wrap upward and downward
        write_reg(3, ALL1);
        cnt_up = 1; tick(); idle();
        chk("R3 wrap up", 32'(count_q), 0);
        cnt_dn = 1; tick(); idle();
        chk("R3 wrap down", 32'(count_q), 32'(ALL1));

        // R2: both strobes high leaves count unchanged
        write_reg(3, 24'd100);
        cnt_up = 1; cnt_dn = 1; tick(); idle();
        chk("R2 up+dn hold", 32'(count_q), 100);

        // R4: load beats write and count
        write_reg(0, 24'h00ABCD);
        load_stb = 1; cnt_up = 1; wr_count = 1; wr_data = 24'd7; tick(); idle();
        chk("R4 load priority", 32'(count_q), 32'h00ABCD);

        // R6: synchronous clear beats load
        clr_async_mode = 0; clr_in = 1; load_stb = 1; tick(); idle();
        chk("R6 sync clear", 32'(count_q), 0);

        // R8: write beats count
        wr_data = 24'd55; wr_count = 1; cnt_dn = 1; tick(); idle();
        chk("R8 write priority", 32'(count_q), 55);

        // R5: snapshot taken at falling edge, held afterwards
        snap_stb = 1; cnt_up = 1; tick(); idle();
        chk("R5 snapshot", 32'(snap_q), 55);
        cnt_up = 1; tick(); idle();
        chk("R5 snapshot held", 32'(snap_q), 55);

        // R7: asynchronous clear without an edge
        clr_async_mode = 1; clr_in = 1;
        #2;
        chk("R7 async clear immediate", 32'(count_q), 0);
        cnt_up = 1; tick(); idle();
        chk("R7 async clear held", 32'(count_q), 0);
        clr_async_mode = 0;
        tick();

        // R9/R10/R12: mode 0 gates channel B
        write_reg(2, 24'd0);
        chk("R9 eq_b gated mode0", 32'(eq_b), 0);
        mode_wr = 1; mode_val = 1; tick(); idle();
        chk("R10 mode1 entered", 32'(ext_b_oe), 1);
        chk("R9 eq_b in mode1", 32'(eq_b), 1);
        extb_sel = 2'd1; abn_in = 1; #1;
        chk("R12 abn source", 32'(ext_b), 1);

        // R13: sticky flag set, cleared by status read
        write_reg(1, 24'd3);
        write_reg(3, 24'd2);
        exta_sel = 2'd2;
        cnt_up = 1; tick(); idle();
        tick();
        chk("R13 sticky set", 32'(ext_a), 1);
        cnt_up = 1; tick(); idle();
        chk("R13 sticky kept", 32'(ext_a), 1);
        status_rd = 1; tick(); idle();
        chk("R13 sticky cleared", 32'(ext_a), 0);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            idle();
            r = $urandom % 4;
            cnt_up = (r == 1) || (r == 3);
            cnt_dn = (r == 2) || (r == 3);
            wr_data = ($urandom % 4 == 0) ? W'($urandom) : W'($urandom % 8);
            wr_count   = ($urandom % 16) == 0;
            wr_preload = ($urandom % 16) == 0;
            wr_refa    = ($urandom % 20) == 0;
            wr_refb    = ($urandom % 20) == 0;
            load_stb   = ($urandom % 24) == 0;
            snap_stb   = ($urandom % 6) == 0;
            status_rd  = ($urandom % 8) == 0;
            clr_in     = ($urandom % 40) == 0;
            if ($urandom % 50 == 0) clr_async_mode = ~clr_async_mode;
            mode_wr    = ($urandom % 30) == 0;
            mode_val   = 1'($urandom);
            exta_sel   = 2'($urandom);
            extb_sel   = 2'($urandom);
            abn_in     = 1'($urandom);
            tick();
        end
        idle();
        clr_async_mode = 0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule